// File: doc/BRIEF.md
# Stream Register Snoop Filter

This block sits beside a set-associative cache and keeps a compact, conservative summary of which line addresses the cache may hold. The summary lives in a small bank of stream registers. Each register has a base address and a care-mask, and covers every address that agrees with its base on the bit positions where the mask is one. A line fill either loads an empty register exactly or widens an existing one by clearing the mask bits where the new address differs from that register's base. A snoop address is then answered with "may be present", which means the cache must be probed, or "definitely absent", which means the cache tag lookup can be skipped.

Masks only ever lose bits, so over time the registers cover more and more of the address space and stop filtering anything. To recover, the block counts replacements in each cache set. The cache replaces lines round-robin within a set, so once every set has seen more replacements than it has ways, every line present before that point has been evicted. This is called a wrap. On the first wrap the active registers move to a shadow bank and the active bank starts over empty. Lookups check both banks. On the next wrap the shadow contents are dropped and replaced by the active bank, and the active bank is cleared again.

Top module: `stream_snoop_filter`

## Requirements
- R1: After synchronous active-low reset, every register in both banks is empty, every snoop is answered "absent", and `snoop_resp_valid` stays low until a snoop is presented.
- R2: A snoop presented with `snoop_valid` high is answered exactly one clock later by a one-cycle `snoop_resp_valid` pulse. The answer reflects register contents from before the edge on which the snoop was taken, so a fill in the same cycle is not yet visible.
- R3: `snoop_may_hit` is 1 when the snoop address agrees with the base of at least one valid register, active or shadow, on every bit where that register's mask is 1. Otherwise it is 0.
- R4: A fill that no valid active register already covers is loaded into the lowest-indexed empty active register, with the fill address as base and an all-ones mask. Other registers are not changed.
- R5: A fill already covered by a valid active register changes no register.
- R6: When all active registers are valid and none covers the fill, the fill merges into the register that needs the fewest mask bits cleared. That register's mask loses exactly the bits where its base differs from the fill address, its base is kept, and no other register changes.
- R7: When two or more registers tie on the number of mask bits to clear in R6, the lowest-indexed one is chosen.
- R8: Each set keeps a replacement counter that saturates at ways+1. A wrap occurs on the edge where a replacement brings the last counter to ways+1, and all counters then return to zero. Replacements to a set whose counter is already saturated do not cause a wrap.
- R9: On a wrap, the active bank is copied to the shadow bank and the active bank is cleared. Addresses covered by the old active bank are still answered "may be present" through the shadow bank.
- R10: On the next wrap, the previous shadow contents are discarded, so addresses covered only by them are answered "absent".
- R11: A fill taken on the same edge as a wrap is loaded into entry 0 of the freshly cleared active bank, with an all-ones mask. It is not copied into the shadow bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_valid | input | 1 | A line fill is taking place this cycle |
| fill_addr | input | ADDR_W | Line address of the fill |
| repl_valid | input | 1 | A replacement occurred in set `repl_set` this cycle |
| repl_set | input | SET_W | Index of the set in which the replacement occurred |
| snoop_valid | input | 1 | A snoop query is presented this cycle |
| snoop_addr | input | ADDR_W | Line address of the snoop |
| snoop_resp_valid | output | 1 | The filter decision is valid this cycle |
| snoop_may_hit | output | 1 | 1 = line may be cached, 0 = line is definitely absent |

## Verification
The bench builds the filter with 8-bit line addresses, two stream registers, two sets and two ways. With these values the active bank fills after two distinct fills, so merges and index ties can be set up with a few hand-picked addresses. A wrap needs only six replacements, so three full wrap cycles fit in a short run, including a cycle where a fill arrives on the same edge as a wrap. The bench also drives extra replacements into a set that is already saturated, to confirm they do not bring the wrap forward. Every expected answer is derived by hand from the base and mask contents implied by the stimulus.

// File: rtl/srf_pkg.sv
// Package: shared definitions for the stream register snoop filter.
// Assumes nothing beyond IEEE 1800-2017.
package srf_pkg;

    // Kind of update a fill causes in the active register bank.
    typedef enum logic [1:0] {
        FILL_NONE  = 2'd0,   // already covered, no change
        FILL_LOAD  = 2'd1,   // load an empty register exactly
        FILL_MERGE = 2'd2    // widen an existing register
    } fill_action_e;

endpackage

// File: rtl/srf_match.sv
// Module: srf_match
// Decides whether an address falls inside any valid register of one bank.
// A register covers an address when they agree on all mask-one bit positions.
// Assumes: purely combinational, with packed arrays indexed by register number.
module srf_match #(
    parameter int ADDR_W   = 16,
    parameter int NUM_REGS = 4
) (
    input  logic [NUM_REGS-1:0]             reg_valid,
    input  logic [NUM_REGS-1:0][ADDR_W-1:0] reg_base,
    input  logic [NUM_REGS-1:0][ADDR_W-1:0] reg_mask,
    input  logic [ADDR_W-1:0]               addr,
    output logic                            hit
);

    logic [NUM_REGS-1:0] per_reg_hit;

    // One comparator per register.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cmp
        assign per_reg_hit[g] = reg_valid[g] &&
                                (((reg_base[g] ^ addr) & reg_mask[g]) == '0);
    end

    // Any covering register makes the address a possible hit.
    assign hit = |per_reg_hit;

endmodule

// File: rtl/srf_alloc.sv
// Module: srf_alloc
// Decides how a fill updates the active bank. If a valid register already
// covers the fill, nothing changes. Otherwise the lowest empty register is
// loaded. With no empty register, the fill merges into the register needing
// the fewest mask bits cleared, with ties going to the lower index.
// Assumes: combinational only; the caller applies the result on its edge.
module srf_alloc
    import srf_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int NUM_REGS = 4,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int COST_W  = $clog2(ADDR_W + 2)
) (
    input  logic [NUM_REGS-1:0]             reg_valid,
    input  logic [NUM_REGS-1:0][ADDR_W-1:0] reg_base,
    input  logic [NUM_REGS-1:0][ADDR_W-1:0] reg_mask,
    input  logic [ADDR_W-1:0]               addr,
    output fill_action_e                    action,
    output logic [IDX_W-1:0]                tgt_idx,
    output logic [ADDR_W-1:0]               new_base,
    output logic [ADDR_W-1:0]               new_mask
);

    logic [NUM_REGS-1:0][COST_W-1:0] cost;
    logic [ADDR_W-1:0]               diff [NUM_REGS];

    // Count mask bits each register would lose to absorb the fill.
    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            diff[i] = (reg_base[i] ^ addr) & reg_mask[i];
            cost[i] = '0;
            for (int b = 0; b < ADDR_W; b++) begin
                cost[i] = cost[i] + COST_W'(diff[i][b]);
            end
        end
    end

    logic              covered;
    logic              have_empty;
    logic [IDX_W-1:0]  empty_idx;
    logic [IDX_W-1:0]  best_idx;
    logic [COST_W-1:0] best_cost;

    // Find coverage, the first empty slot and the cheapest valid register.
    always_comb begin
        covered    = 1'b0;
        have_empty = 1'b0;
        empty_idx  = '0;
        best_idx   = '0;
        best_cost  = COST_W'(ADDR_W + 1);
        for (int i = 0; i < NUM_REGS; i++) begin
            if (reg_valid[i]) begin
                if (cost[i] == '0) covered = 1'b1;
                if (cost[i] < best_cost) begin
                    best_cost = cost[i];
                    best_idx  = IDX_W'(i);
                end
            end else if (!have_empty) begin
                have_empty = 1'b1;
                empty_idx  = IDX_W'(i);
            end
        end
    end

    // Form the update for the chosen register.
    always_comb begin
        action   = FILL_NONE;
        tgt_idx  = '0;
        new_base = addr;
        new_mask = '1;
        if (covered) begin
            action = FILL_NONE;
        end else if (have_empty) begin
            action  = FILL_LOAD;
            tgt_idx = empty_idx;
        end else begin
            action   = FILL_MERGE;
            tgt_idx  = best_idx;
            new_base = reg_base[best_idx];
            new_mask = reg_mask[best_idx] & ~(reg_base[best_idx] ^ addr);
        end
    end

    // R6: a merge may only clear mask bits, never set them
    always_comb begin
        if (action == FILL_MERGE) begin
            merge_shrinks_chk: assert ((new_mask & ~reg_mask[tgt_idx]) == '0);
        end
    end

endmodule

// File: rtl/srf_wrap_detect.sv
// Module: srf_wrap_detect
// Keeps one replacement counter per cache set, each saturating at ways+1.
// It signals a wrap on the edge where the last counter saturates, and
// clears all counters on that edge.
// Assumes: the cache replaces round-robin within a set, and set indices
// at or beyond NUM_SETS are never presented.
module srf_wrap_detect #(
    parameter int NUM_SETS = 8,
    parameter int NUM_WAYS = 4,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int CNT_W   = $clog2(NUM_WAYS + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             repl_valid,
    input  logic [SET_W-1:0] repl_set,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] SAT = CNT_W'(NUM_WAYS + 1);

    logic [NUM_SETS-1:0][CNT_W-1:0] cnt_q;
    logic [NUM_SETS-1:0][CNT_W-1:0] cnt_d;
    logic                           all_sat;

    // Next counter values, and whether all counters saturate with this event.
    always_comb begin
        all_sat = 1'b1;
        for (int s = 0; s < NUM_SETS; s++) begin
            cnt_d[s] = cnt_q[s];
            if (repl_valid && (repl_set == SET_W'(s)) && (cnt_q[s] != SAT)) begin
                cnt_d[s] = cnt_q[s] + 1'b1;
            end
            if (cnt_d[s] != SAT) all_sat = 1'b0;
        end
    end

    // A wrap needs a replacement on this cycle that completes saturation.
    assign wrap = repl_valid && all_sat;

    // Counter state, cleared at reset and at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (wrap)  cnt_q <= '0;
        else            cnt_q <= cnt_d;
    end

    for (genvar g = 0; g < NUM_SETS; g++) begin : g_bound
        // R8
        cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q[g] <= SAT);
    end

    // R8
    wrap_needs_repl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> repl_valid);

endmodule

// File: rtl/stream_snoop_filter.sv
// Module: stream_snoop_filter (top)
// Summarises the lines held by a cache with an active and a shadow bank of
// base/mask stream registers, and answers snoops one cycle later with
// "may be present" or "definitely absent". A cache wrap moves the active
// bank into the shadow bank and clears the active bank.
// Assumes: fill, replacement and snoop events each last one cycle;
// synchronous active-low reset.
module stream_snoop_filter
    import srf_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int NUM_REGS = 4,
    parameter int NUM_SETS = 8,
    parameter int NUM_WAYS = 4,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              repl_valid,
    input  logic [SET_W-1:0]  repl_set,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              snoop_resp_valid,
    output logic              snoop_may_hit
);

    logic [NUM_REGS-1:0]             act_valid, shd_valid;
    logic [NUM_REGS-1:0][ADDR_W-1:0] act_base, act_mask;
    logic [NUM_REGS-1:0][ADDR_W-1:0] shd_base, shd_mask;

    logic              wrap;
    logic              hit_act, hit_shd;
    fill_action_e      action;
    logic [IDX_W-1:0]  tgt_idx;
    logic [ADDR_W-1:0] new_base, new_mask;

    srf_wrap_detect #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_wrap (
        .clk        (clk),
        .rst_n      (rst_n),
        .repl_valid (repl_valid),
        .repl_set   (repl_set),
        .wrap       (wrap)
    );

    srf_match #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_match_act (
        .reg_valid (act_valid),
        .reg_base  (act_base),
        .reg_mask  (act_mask),
        .addr      (snoop_addr),
        .hit       (hit_act)
    );

    srf_match #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_match_shd (
        .reg_valid (shd_valid),
        .reg_base  (shd_base),
        .reg_mask  (shd_mask),
        .addr      (snoop_addr),
        .hit       (hit_shd)
    );

    srf_alloc #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_alloc (
        .reg_valid (act_valid),
        .reg_base  (act_base),
        .reg_mask  (act_mask),
        .addr      (fill_addr),
        .action    (action),
        .tgt_idx   (tgt_idx),
        .new_base  (new_base),
        .new_mask  (new_mask)
    );

    // Register banks: wrap rotates the banks; otherwise a fill updates one entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_valid <= '0;
            act_base  <= '0;
            act_mask  <= '0;
            shd_valid <= '0;
            shd_base  <= '0;
            shd_mask  <= '0;
        end else if (wrap) begin
            shd_valid <= act_valid;
            shd_base  <= act_base;
            shd_mask  <= act_mask;
            act_valid <= '0;
            if (fill_valid) begin
                act_valid[0] <= 1'b1;
                act_base[0]  <= fill_addr;
                act_mask[0]  <= '1;
            end
        end else if (fill_valid && (action != FILL_NONE)) begin
            act_valid[tgt_idx] <= 1'b1;
            act_base[tgt_idx]  <= new_base;
            act_mask[tgt_idx]  <= new_mask;
        end
    end

    // Snoop answer, registered one cycle after the query.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snoop_resp_valid <= 1'b0;
            snoop_may_hit    <= 1'b0;
        end else begin
            snoop_resp_valid <= snoop_valid;
            snoop_may_hit    <= snoop_valid && (hit_act || hit_shd);
        end
    end

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (act_valid == '0) && (shd_valid == '0));

    // R2
    resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_valid |=> snoop_resp_valid);

    // R2
    resp_only_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !snoop_valid |=> !snoop_resp_valid);

    // R4
    fill_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !wrap) |=> $countones(act_valid) >= $past($countones(act_valid)));

    // R9
    wrap_clears_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> $countones(act_valid) <= 1);

    // R3
    absent_means_nomatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_resp_valid && !snoop_may_hit) |-> $past(!hit_act && !hit_shd));

endmodule

// File: tb/stream_snoop_filter_tb.sv
// Bench: scoreboard-style check of stream_snoop_filter with small parameters.
module stream_snoop_filter_tb;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fill_valid = 1'b0;
    logic [AW-1:0] fill_addr = '0;
    logic          repl_valid = 1'b0;
    logic [0:0]    repl_set = '0;
    logic          snoop_valid = 1'b0;
    logic [AW-1:0] snoop_addr = '0;
    logic          snoop_resp_valid;
    logic          snoop_may_hit;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    typedef struct {
        logic  exp;
        string req;
        logic [AW-1:0] addr;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    stream_snoop_filter #(
        .ADDR_W(AW), .NUM_REGS(2), .NUM_SETS(2), .NUM_WAYS(2)
    ) u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .fill_valid       (fill_valid),
        .fill_addr        (fill_addr),
        .repl_valid       (repl_valid),
        .repl_set         (repl_set),
        .snoop_valid      (snoop_valid),
        .snoop_addr       (snoop_addr),
        .snoop_resp_valid (snoop_resp_valid),
        .snoop_may_hit    (snoop_may_hit)
    );

    // Driver: one cycle of stimulus; a snoop pushes its expected answer.
    task automatic drive(input logic fv, input logic [AW-1:0] fa,
                         input logic rv, input logic rs,
                         input logic sv, input logic [AW-1:0] sa,
                         input logic ex, input string rq);
        @(negedge clk);
        fill_valid  = fv;  fill_addr  = fa;
        repl_valid  = rv;  repl_set   = rs;
        snoop_valid = sv;  snoop_addr = sa;
        if (sv) exp_q.push_back('{ex, rq, sa});
    endtask

    task automatic fill(input logic [AW-1:0] a);
        drive(1'b1, a, 1'b0, 1'b0, 1'b0, '0, 1'b0, "");
    endtask
    task automatic repl(input logic s);
        drive(1'b0, '0, 1'b1, s, 1'b0, '0, 1'b0, "");
    endtask
    task automatic snoop(input logic [AW-1:0] a, input logic ex, input string rq);
        drive(1'b0, '0, 1'b0, 1'b0, 1'b1, a, ex, rq);
    endtask
    task automatic idle();
        drive(1'b0, '0, 1'b0, 1'b0, 1'b0, '0, 1'b0, "");
    endtask

    // Monitor: pop and compare each response as it appears.
    always @(negedge clk) begin
        if (rst_n && !done && snoop_resp_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2: unexpected response, actual=1 expected=0 (no snoop pending)");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (snoop_may_hit !== e.exp) begin
                    errors++;
                    $display("FAIL %s: snoop %h actual=%0b expected=%0b",
                             e.req, e.addr, snoop_may_hit, e.exp);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: no response without a snoop after reset
        checks++;
        if (snoop_resp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: resp_valid actual=%0b expected=0", snoop_resp_valid);
        end
        snoop(8'h00, 1'b0, "R1");
        snoop(8'h01, 1'b0, "R1");

        // R4: exact load into empty registers
        fill(8'h01);
        snoop(8'h01, 1'b1, "R4");
        snoop(8'h03, 1'b0, "R4");
        fill(8'h80);
        snoop(8'h80, 1'b1, "R4");
        snoop(8'h81, 1'b0, "R4");

        // R6: merge 03 into reg0 (cost 1 vs 3) -> reg0 covers 0000_00x1
        fill(8'h03);
        snoop(8'h03, 1'b1, "R6");
        snoop(8'h07, 1'b0, "R3");
        snoop(8'h81, 1'b0, "R6");

        // R5: covered fill changes nothing
        fill(8'h03);
        snoop(8'h07, 1'b0, "R5");
        snoop(8'h02, 1'b0, "R5");

        // R7: 81 ties (1 bit each) -> reg0 mask 7D
        fill(8'h81);
        snoop(8'h83, 1'b1, "R7");
        snoop(8'h82, 1'b0, "R7");

        // R6: C0 cheaper in reg1 -> reg1 mask BF
        fill(8'hC0);
        snoop(8'hC0, 1'b1, "R6");
        snoop(8'h41, 1'b0, "R3");
        snoop(8'hC1, 1'b0, "R6");

        // R2: same-cycle fill is invisible to that snoop
        drive(1'b1, 8'h44, 1'b0, 1'b0, 1'b1, 8'h44, 1'b0, "R2");
        snoop(8'h44, 1'b1, "R2");

        // R8: saturated set does not bring the wrap forward
        repl(1'b0); repl(1'b0); repl(1'b0);
        repl(1'b1); repl(1'b1);
        snoop(8'h01, 1'b1, "R8");
        repl(1'b0); repl(1'b0);
        snoop(8'h01, 1'b1, "R8");
        repl(1'b1);                       // wrap 1
        // R9: old contents visible through shadow, active cleared
        snoop(8'h01, 1'b1, "R9");
        snoop(8'h44, 1'b1, "R9");
        fill(8'h10);
        snoop(8'h10, 1'b1, "R9");
        snoop(8'h11, 1'b0, "R9");

        // R10: shadow survives until the next full wrap
        repl(1'b1); repl(1'b1); repl(1'b1);
        repl(1'b0); repl(1'b0);
        snoop(8'h01, 1'b1, "R10");
        // R11: wrap 2 with a simultaneous fill of 20
        drive(1'b1, 8'h20, 1'b1, 1'b0, 1'b0, '0, 1'b0, "");
        snoop(8'h01, 1'b0, "R10");
        snoop(8'h44, 1'b0, "R10");
        snoop(8'h10, 1'b1, "R10");
        snoop(8'h20, 1'b1, "R11");
        snoop(8'h21, 1'b0, "R11");

        // wrap 3: 10 discarded, 20 moves to shadow
        repl(1'b0); repl(1'b0); repl(1'b0);
        repl(1'b1); repl(1'b1); repl(1'b1);
        snoop(8'h10, 1'b0, "R10");
        snoop(8'h20, 1'b1, "R11");

        idle(); idle(); idle();
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2: pending responses actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule